// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Peripheral Slave

This block connects a small bank of 16-bit registers to an external bus on which address and data share the same sixteen AD pins. A bus-phase strobe, E, sets the phase. While E is low the pins carry an address. While E is high they carry data. The block runs on its own system clock, which is much faster than E, and treats E, R/W, the low-byte strobe and the AD inputs as signals already synchronised to that clock.

The address is held as the last value seen while E was low, which is the value present at the rising edge of E. The upper address bits are compared with a fixed base to give a chip select. The low address bit and the low-byte strobe together pick the byte lanes. A write is committed when E falls, using the last data seen while E was high. A read drives the selected word while E is high and holds it until one clock after E falls. The AD pad is split into an input, an output and an output enable, so the tristate buffer sits in the pad ring.

Top module: `mbus_periph`

## Requirements
- R1: After reset every word of the bank is 0x0000, `ad_oe_o` is 0 and `ad_o` is 0x0000.
- R2: The target address is the last `ad_i` value seen while `e_i` was low. Values that appear on `ad_i` while `e_i` is high do not change which word is accessed.
- R3: An access is accepted only when the address bits above the block size equal the matching bits of `BASE_ADDR`. Writes to any other address change no word, and reads from any other address never assert `ad_oe_o`.
- R4: With address bit 0 low and `lstrb_i` low, a write updates the whole word. `ad[15:8]` goes to the even (upper) byte and `ad[7:0]` goes to the odd (lower) byte. The word index is address bits [ABITS-1:1].
- R5: With address bit 0 low and `lstrb_i` high, a write updates only the upper byte from `ad[15:8]`.
- R6: With address bit 0 high and `lstrb_i` low, a write updates only the lower byte from `ad[7:0]`.
- R7: Address bit 0 high together with `lstrb_i` high is no access: nothing is written and nothing is driven.
- R8: A write takes effect on the clock that sees `e_i` fall, with the data last seen while `e_i` was high. The bank stays unchanged while `e_i` is still high.
- R9: A valid selected read asserts `ad_oe_o` and presents the addressed word on `ad_o` while `e_i` and `rw_i` are high. Both stay valid through the falling edge of E and are released one clock later.
- R10: While `rw_i` is low (write), `ad_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e_i | input | 1 | Bus phase strobe: low = address phase, high = data phase |
| rw_i | input | 1 | Direction: 1 = read, 0 = write |
| lstrb_i | input | 1 | Active-low low-byte strobe |
| ad_i | input | 16 | Multiplexed address/data from the pad |
| ad_o | output | 16 | Read data towards the pad |
| ad_oe_o | output | 1 | Pad output enable |
| bank_o | output | NWORDS*16 | Register bank contents, word 0 in the least significant bits |

## Verification
The write path is tried with all four combinations of the low address bit and the byte strobe. Each of these leaves a distinct pattern of bytes changed in a known word, so a swapped lane or a missing no-access case shows up directly. Two further patterns move `ad_i` during a phase. Changing it during the address phase, and again during the data phase, shows whether the address is the last low-phase value and whether the data is the last high-phase value. Reads inside and outside the decoded window, with enable sampled just before and just after E falls, separate a correct hold from an early release or a stray drive.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef struct packed {
        logic hi;   // even byte, ad[15:8]
        logic lo;   // odd byte, ad[7:0]
    } lanes_t;

    // Byte-lane selection from the low address bit and active-low strobe.
    function automatic lanes_t lane_decode(input logic a0, input logic lstrb_n);
        lanes_t l;
        case ({a0, lstrb_n})
            2'b00:   l = '{hi: 1'b1, lo: 1'b1};
            2'b01:   l = '{hi: 1'b1, lo: 1'b0};
            2'b10:   l = '{hi: 1'b0, lo: 1'b1};
            default: l = '{hi: 1'b0, lo: 1'b0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/mbus_phase.sv
// Tracks the E phase and captures address (low phase) and data (high phase).
module mbus_phase #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          e_i,
    input  logic          rw_i,
    input  logic          lstrb_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          rw_o,
    output logic          lstrb_o,
    output logic          e_fall_o
);

    typedef struct packed {
        logic          e;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
        logic          rw;
        logic          lstrb;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.e = e_i;
        if (!e_i) begin
            st_d.addr = ad_i;
        end else begin
            st_d.data  = ad_i;
            st_d.rw    = rw_i;
            st_d.lstrb = lstrb_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{e: 1'b0, addr: '0, data: '0, rw: 1'b1, lstrb: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o   = st_q.addr;
    assign data_o   = st_q.data;
    assign rw_o     = st_q.rw;
    assign lstrb_o  = st_q.lstrb;
    assign e_fall_o = st_q.e & ~e_i;

endmodule

// File: rtl/mbus_decode.sv
// Chip select against a fixed base and word index inside the window.
module mbus_decode #(
    parameter int          DW        = 16,
    parameter int          NWORDS    = 4,
    parameter logic [15:0] BASE_ADDR = 16'h0400
) (
    input  logic [DW-1:0]               addr_i,
    output logic                        sel_o,
    output logic [$clog2(NWORDS)-1:0]   idx_o
);

    localparam int IW    = $clog2(NWORDS);
    localparam int ABITS = IW + 1;

    logic [DW-1:0] base_w;

    always_comb begin
        base_w = DW'(BASE_ADDR);
        sel_o  = (addr_i[DW-1:ABITS] == base_w[DW-1:ABITS]);
        idx_o  = addr_i[ABITS-1:1];
    end

endmodule

// File: rtl/mbus_regbank.sv
// Word storage with independent byte-lane writes.
module mbus_regbank #(
    parameter int DW     = 16,
    parameter int NWORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NWORDS-1:0]         wr_word_i,
    input  logic                      we_hi_i,
    input  logic                      we_lo_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic [$clog2(NWORDS)-1:0] ridx_i,
    output logic [DW-1:0]             rdata_o,
    output logic [NWORDS*DW-1:0]      bank_o
);

    localparam int HB = DW / 2;

    logic [DW-1:0] word_q [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [DW-1:0] word_d;

        always_comb begin
            word_d = word_q[w];
            if (wr_word_i[w]) begin
                if (we_hi_i) word_d[DW-1:HB] = wdata_i[DW-1:HB];
                if (we_lo_i) word_d[HB-1:0]  = wdata_i[HB-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q[w] <= '0;
            else        word_q[w] <= word_d;
        end

        assign bank_o[w*DW +: DW] = word_q[w];
    end

    assign rdata_o = word_q[ridx_i];

endmodule

// File: rtl/mbus_periph.sv
module mbus_periph
    import mbus_pkg::*;
#(
    parameter int          NWORDS    = 4,
    parameter logic [15:0] BASE_ADDR = 16'h0400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 e_i,
    input  logic                 rw_i,
    input  logic                 lstrb_i,
    input  logic [15:0]          ad_i,
    output logic [15:0]          ad_o,
    output logic                 ad_oe_o,
    output logic [NWORDS*16-1:0] bank_o
);

    localparam int DW = 16;
    localparam int IW = $clog2(NWORDS);

    logic [DW-1:0]     lat_addr, lat_data;
    logic              lat_rw, lat_lstrb, e_fall;
    logic              sel;
    logic [IW-1:0]     idx;
    logic [DW-1:0]     rdata;
    logic [NWORDS-1:0] wr_word;
    lanes_t            wl, rl;

    mbus_phase #(.DW(DW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .e_i      (e_i),
        .rw_i     (rw_i),
        .lstrb_i  (lstrb_i),
        .ad_i     (ad_i),
        .addr_o   (lat_addr),
        .data_o   (lat_data),
        .rw_o     (lat_rw),
        .lstrb_o  (lat_lstrb),
        .e_fall_o (e_fall)
    );

    mbus_decode #(.DW(DW), .NWORDS(NWORDS), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr_i (lat_addr),
        .sel_o  (sel),
        .idx_o  (idx)
    );

    // Write commit at the E fall, lanes from values held in the data phase.
    always_comb begin
        wl      = lane_decode(lat_addr[0], lat_lstrb);
        wr_word = '0;
        if (e_fall && !lat_rw && sel && (wl.hi || wl.lo)) begin
            wr_word[idx] = 1'b1;
        end
    end

    mbus_regbank #(.DW(DW), .NWORDS(NWORDS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_word_i (wr_word),
        .we_hi_i   (wl.hi),
        .we_lo_i   (wl.lo),
        .wdata_i   (lat_data),
        .ridx_i    (idx),
        .rdata_o   (rdata),
        .bank_o    (bank_o)
    );

    typedef struct packed {
        logic          oe;
        logic [DW-1:0] dout;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        rl         = lane_decode(lat_addr[0], lstrb_i);
        drv_d.oe   = e_i && rw_i && sel && (rl.hi || rl.lo);
        drv_d.dout = drv_d.oe ? rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign ad_oe_o = drv_q.oe;
    assign ad_o    = drv_q.dout;

endmodule

// File: rtl/mbus_periph_chk.sv
module mbus_periph_chk #(
    parameter int NWORDS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 e_i,
    input logic                 rw_i,
    input logic                 lstrb_i,
    input logic                 lat_a0,
    input logic                 ad_oe_o,
    input logic [NWORDS-1:0]    wr_word,
    input logic [NWORDS*16-1:0] bank_o
);

    assert_oe_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> $past(e_i) && $past(rw_i));

    assert_no_drive_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_i |=> !ad_oe_o);

    assert_bad_combo_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (e_i && rw_i && lat_a0 && lstrb_i) |=> !ad_oe_o);

    assert_commit_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_o) |-> !$past(e_i) && $past(e_i, 2));

    assert_single_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_word));

endmodule

bind mbus_periph mbus_periph_chk #(.NWORDS(NWORDS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .e_i     (e_i),
    .rw_i    (rw_i),
    .lstrb_i (lstrb_i),
    .lat_a0  (lat_addr[0]),
    .ad_oe_o (ad_oe_o),
    .wr_word (wr_word),
    .bank_o  (bank_o)
);

// File: tb/mbus_periph_tb.sv
module mbus_periph_tb;

    localparam int NW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           e_i = 1'b0, rw_i = 1'b1, lstrb_i = 1'b1;
    logic [15:0]    ad_i = '0;
    logic [15:0]    ad_o;
    logic           ad_oe_o;
    logic [NW*16-1:0] bank_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_w [NW];

    always #2 clk = ~clk;

    mbus_periph #(.NWORDS(NW), .BASE_ADDR(16'h0400)) u_dut (
        .clk(clk), .rst_n(rst_n), .e_i(e_i), .rw_i(rw_i), .lstrb_i(lstrb_i),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .bank_o(bank_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_bank(input string req);
        for (int w = 0; w < NW; w++) check(req, bank_o[w*16 +: 16], exp_w[w]);
    endtask

    // Address phase: optional decoy first, then the real address.
    task automatic addr_phase(input logic [15:0] a, input logic rw, input logic ls);
        @(negedge clk); e_i = 1'b0; rw_i = rw; lstrb_i = ls; ad_i = 16'h0406;
        @(negedge clk); ad_i = a;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_write(input string req, input logic [15:0] a, input logic ls,
                             input logic [15:0] d, input logic [15:0] decoy);
        addr_phase(a, 1'b0, ls);
        e_i = 1'b1; ad_i = decoy;                 // R2/R8: decoy seen in data phase
        repeat (2) @(negedge clk);
        ad_i = d;
        repeat (2) @(negedge clk);
        check("R10", {15'd0, ad_oe_o}, 16'd0);
        check_bank("R8");                         // unchanged before the fall
        e_i = 1'b0; ad_i = 16'hFFFF;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input string req, input logic [15:0] a, input logic ls,
                            input logic drive, input logic [15:0] expv);
        addr_phase(a, 1'b1, ls);
        e_i = 1'b1; ad_i = 16'h0000;
        repeat (3) @(negedge clk);
        check(req, {15'd0, ad_oe_o}, {15'd0, drive});
        if (drive) check(req, ad_o, expv);
        e_i = 1'b0;
        #1;
        check("R9", {15'd0, ad_oe_o}, {15'd0, drive});   // held through the fall
        @(negedge clk);
        check("R9", {15'd0, ad_oe_o}, 16'd0);             // released one clock later
    endtask

    task automatic t_reset;
        for (int w = 0; w < NW; w++) exp_w[w] = '0;
        check_bank("R1");
        check("R1", {15'd0, ad_oe_o}, 16'd0);
        check("R1", ad_o, 16'h0000);
    endtask

    task automatic t_full_write;
        bus_write("R4", 16'h0400, 1'b0, 16'hA1B2, 16'h0402);
        exp_w[0] = 16'hA1B2;
        check_bank("R4");
        bus_read("R9", 16'h0400, 1'b0, 1'b1, 16'hA1B2);
    endtask

    task automatic t_byte_writes;
        bus_write("R4", 16'h0402, 1'b0, 16'h1122, 16'h0000);
        exp_w[1] = 16'h1122;
        check_bank("R4");
        bus_write("R5", 16'h0402, 1'b1, 16'h55EE, 16'h0000);
        exp_w[1] = 16'h5522;
        check_bank("R5");
        bus_write("R6", 16'h0403, 1'b0, 16'hEE77, 16'h0000);
        exp_w[1] = 16'h5577;
        check_bank("R6");
        bus_read("R9", 16'h0403, 1'b0, 1'b1, 16'h5577);
    endtask

    task automatic t_no_access;
        bus_write("R7", 16'h0405, 1'b1, 16'hDEAD, 16'h0000);
        check_bank("R7");
        bus_read("R7", 16'h0405, 1'b1, 1'b0, 16'h0000);
    endtask

    task automatic t_outside;
        bus_write("R3", 16'h0800, 1'b0, 16'hBEEF, 16'h0000);
        check_bank("R3");
        bus_read("R3", 16'h0800, 1'b0, 1'b0, 16'h0000);
        bus_write("R3", 16'h0407, 1'b0, 16'h0F0F, 16'h0000);  // last word, odd byte
        exp_w[3] = 16'h000F;
        check_bank("R3");
    endtask

    task automatic t_addr_hold;
        // decoy 0x0406 shown first in address phase; data-phase decoy 0x0406 too
        bus_write("R2", 16'h0404, 1'b0, 16'h3C3C, 16'h0406);
        exp_w[2] = 16'h3C3C;
        check_bank("R2");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_byte_writes();
        t_no_access();
        t_outside();
        t_addr_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule